// File: doc/BRIEF.md
# Multi-Pattern One-Hot NFA Byte Matcher

This block scans a byte stream for five fixed patterns at the same time and raises one flag per pattern whenever an occurrence ends. The patterns are `ab+cd`, `ab+ce`, `ab+c.*f`, `b[d-f]a` and `bdc`. Letters compare without regard to case. Each position inside the patterns is a single flip-flop. Any number of these flip-flops can be set together, so overlapping and concurrent partial matches are all tracked with no backtracking.

A single shared decoder turns each input byte into six letter-class lines (a through f). Each class line is the OR of the upper-case and lower-case compares. Every state flop is set from its predecessor states and one class line. The start state is a constant: it is always active, so a pattern can begin at any byte of the stream.

A flow-clear input drops all partial progress between unrelated streams. A dual-byte mode consumes two bytes in one clock. In that mode the transition logic is chained twice within the cycle.

Top module: `nfa_multi_matcher`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `match_o` is all zeros and no partial pattern progress is retained.
- R2: Each letter a–f in a pattern matches byte 0x61–0x66 or the matching 0x41–0x46. Any other byte matches no letter.
- R3: `match_o[0]` flags `ab+cd` and `match_o[1]` flags `ab+ce`. The `b` run may be any length of at least one.
- R4: `match_o[2]` flags `ab+c.*f`. After any `ab+c` in the current flow, every later `f` raises the bit, whatever bytes come between. This holds until a flow clear.
- R5: `match_o[3]` flags `b` then one of d/e/f then `a`. `match_o[4]` flags `bdc`.
- R6: Matching is unanchored. Occurrences that share bytes with earlier occurrences, of the same pattern or another, are each reported.
- R7: A match bit is high in exactly the cycle after the clock edge that accepts the final byte. It is low in any cycle whose preceding edge had no valid byte. In one-byte mode at most one bit is high at a time.
- R8: A cycle with `in_valid` low leaves all pattern progress unchanged, whatever is on the byte inputs.
- R9: `flow_clr` takes priority over `in_valid`. It discards the byte presented with it and cancels all partial progress, including an armed `.*`. The following cycle shows zero matches.
- R10: With `in_dual` high, `in_byte0` is consumed first and then `in_byte1`. Each match bit is the OR of the accepts on the two bytes, so two different bits can rise together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_clr | input | 1 | Synchronous flow restart; cancels all progress |
| in_valid | input | 1 | Byte(s) on the inputs are to be consumed this cycle |
| in_dual | input | 1 | Consume `in_byte1` after `in_byte0` in the same cycle |
| in_byte0 | input | 8 | First (or only) stream byte |
| in_byte1 | input | 8 | Second stream byte in dual mode |
| match_o | output | 5 | Per-pattern match flags, registered |

## Verification
Two functions can fall in the same cycle: a flow clear and a valid byte that would complete a pattern. The bench builds up `abbc` and then raises `flow_clr` while `d` is valid. It judges the result by a zero `match_o` and by the absence of a match on a following `d`. It does the same after an armed `.*` with a later `f`.

A second coincidence is a dual-mode pair in which both bytes complete different patterns. The pair `d`,`f` after `abc` must raise bits 0 and 2 together.

All strings of length four over a small alphabet are swept in both modes. The results are compared with a history-scanning model of the five patterns.

// File: rtl/nfa_multi_matcher.sv
module nfa_multi_matcher (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flow_clr,
  input  logic       in_valid,
  input  logic       in_dual,
  input  logic [7:0] in_byte0,
  input  logic [7:0] in_byte1,
  output logic [4:0] match_o
);
  localparam int NS = 7;
  localparam int NP = 5;
  localparam int NK = 6;
  localparam int NW = NP + NS;

  // class k is letter 'a'+k, either case
  function automatic logic [NK-1:0] decode(input logic [7:0] c);
    logic [NK-1:0] k;
    for (int i = 0; i < NK; i++)
      k[i] = (c == 8'(8'h61 + i)) || (c == 8'(8'h41 + i));
    return k;
  endfunction

  // s: 0 a, 1 ab+, 2 ab+c, 3 dot-star, 4 b, 5 b[d-f], 6 bd
  function automatic logic [NW-1:0] step(input logic [NS-1:0] s, input logic [NK-1:0] k);
    logic [NS-1:0] n;
    logic [NP-1:0] a;
    n[0] = k[0];
    n[1] = (s[0] | s[1]) & k[1];
    n[2] = s[1] & k[2];
    n[3] = s[2] | s[3];
    n[4] = k[1];
    n[5] = s[4] & (k[3] | k[4] | k[5]);
    n[6] = s[4] & k[3];
    a[0] = s[2] & k[3];
    a[1] = s[2] & k[4];
    a[2] = (s[2] | s[3]) & k[5];
    a[3] = s[5] & k[0];
    a[4] = s[6] & k[2];
    return {a, n};
  endfunction

  logic [NS-1:0] st_q;
  logic [NK-1:0] cls0, cls1;
  logic [NW-1:0] r0, r1;
  logic [NS-1:0] st_nx;
  logic [NP-1:0] acc;

  assign cls0  = decode(in_byte0);
  assign cls1  = decode(in_byte1);
  assign r0    = step(st_q, cls0);
  assign r1    = step(r0[NS-1:0], cls1);
  assign st_nx = in_dual ? r1[NS-1:0] : r0[NS-1:0];
  assign acc   = r0[NW-1:NS] | (in_dual ? r1[NW-1:NS] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      match_o <= '0;
    end else if (flow_clr) begin
      st_q    <= '0;
      match_o <= '0;
    end else if (in_valid) begin
      st_q    <= st_nx;
      match_o <= acc;
    end else begin
      match_o <= '0;
    end
  end
endmodule

module nfa_multi_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flow_clr,
  input logic       in_valid,
  input logic       in_dual,
  input logic [7:0] in_byte0,
  input logic [7:0] in_byte1,
  input logic [4:0] match_o
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  function automatic logic is_ch(input logic [7:0] c, input logic [7:0] lc);
    return (c == lc) || (c == 8'(lc - 8'h20));
  endfunction

  always_ff @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (match_o == 5'b0);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!in_valid)) |-> match_o == 5'b0);

  p_clr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(flow_clr)) |-> match_o == 5'b0);

  p_single_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && !in_dual)) |-> $onehot0(match_o));

  p_cd_ends_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && match_o[0]) |-> $past(is_ch(in_byte0, 8'h64) || (in_dual && is_ch(in_byte1, 8'h64))));

  p_dotstar_ends_f_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && match_o[2]) |-> $past(is_ch(in_byte0, 8'h66) || (in_dual && is_ch(in_byte1, 8'h66))));

  p_bxa_ends_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && match_o[3]) |-> $past(is_ch(in_byte0, 8'h61) || (in_dual && is_ch(in_byte1, 8'h61))));

  p_dual_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_dual && !flow_clr)) |-> $countones(match_o) <= 2);
endmodule

bind nfa_multi_matcher nfa_multi_matcher_chk u_chk (.*);

// File: tb/nfa_multi_matcher_tb.sv
module nfa_multi_matcher_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flow_clr = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_dual = 1'b0;
  logic [7:0] in_byte0 = 8'h00;
  logic [7:0] in_byte1 = 8'h00;
  logic [4:0] match_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] hist [512];
  int hlen = 0;

  nfa_multi_matcher u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] low(input logic [7:0] c);
    return (c >= 8'h41 && c <= 8'h5a) ? 8'(c + 8'h20) : c;
  endfunction

  function automatic bit abc_at(input int m);
    int k;
    int n;
    if (m < 2 || hist[m] != "c") return 0;
    k = m - 1;
    n = 0;
    while (k >= 0 && hist[k] == "b") begin n++; k--; end
    return n >= 1 && k >= 0 && hist[k] == "a";
  endfunction

  function automatic logic [4:0] ref_acc(input int i);
    logic [4:0] r = '0;
    r[0] = hist[i] == "d" && i >= 1 && abc_at(i - 1);
    r[1] = hist[i] == "e" && i >= 1 && abc_at(i - 1);
    if (hist[i] == "f")
      for (int m = 0; m < i; m++) if (abc_at(m)) r[2] = 1'b1;
    r[3] = i >= 2 && hist[i] == "a" && hist[i-1] >= "d" && hist[i-1] <= "f" && hist[i-2] == "b";
    r[4] = i >= 2 && hist[i] == "c" && hist[i-1] == "d" && hist[i-2] == "b";
    return r;
  endfunction

  function automatic logic [4:0] push(input logic [7:0] c);
    logic [4:0] r;
    hist[hlen] = low(c);
    r = ref_acc(hlen);
    if (hlen < 511) hlen++;
    return r;
  endfunction

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: match_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b0, input logic [7:0] b1, input bit dual, input string tag);
    logic [4:0] exp;
    in_valid = 1'b1; in_dual = dual; in_byte0 = b0; in_byte1 = b1;
    exp = push(b0);
    if (dual) exp |= push(b1);
    @(negedge clk);
    in_valid = 1'b0; in_dual = 1'b0;
    check(match_o, exp, tag);
  endtask

  task automatic feed_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) feed(s[i], 8'h00, 1'b0, tag);
  endtask

  task automatic feed_pairs(input string s, input string tag);
    for (int i = 0; i + 1 < s.len(); i += 2) feed(s[i], s[i+1], 1'b1, tag);
  endtask

  task automatic clear_flow(input string tag);
    flow_clr = 1'b1; in_valid = 1'b1; in_byte0 = "d"; in_byte1 = "f"; in_dual = 1'b1;
    @(negedge clk);
    flow_clr = 1'b0; in_valid = 1'b0; in_dual = 1'b0;
    hlen = 0;
    check(match_o, 5'b0, tag);
  endtask

  task automatic idle(input int n, input logic [7:0] junk);
    for (int i = 0; i < n; i++) begin
      in_byte0 = junk; in_byte1 = junk;
      @(negedge clk);
      check(match_o, 5'b0, "R8");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] alpha [8];
    alpha = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h42, 8'h78};
    repeat (3) @(negedge clk);
    check(match_o, 5'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(match_o, 5'b0, "R1");

    feed_str("abbbbbbcd", "R3");  check(match_o, 5'b00001, "R3");
    feed_str("xabce", "R3");      check(match_o, 5'b00010, "R3");
    clear_flow("R9");
    feed_str("aBbCD", "R2");      check(match_o, 5'b00001, "R2");
    clear_flow("R9");
    feed_str("ABCE", "R2");       check(match_o, 5'b00010, "R2");
    feed_str("b`a", "R2");        check(match_o, 5'b00000, "R2");
    clear_flow("R9");
    feed_str("abcxyzzzf", "R4");  check(match_o, 5'b00100, "R4");
    feed_str("qqF", "R4");        check(match_o, 5'b00100, "R4");
    clear_flow("R9");
    feed_str("bea", "R5");        check(match_o, 5'b01000, "R5");
    feed_str("bfa", "R5");
    feed_str("bga", "R5");        check(match_o, 5'b00000, "R5");
    feed_str("bdC", "R5");        check(match_o, 5'b10000, "R5");
    feed_str("abcdf", "R6");      check(match_o, 5'b00100, "R6");
    feed_str("bdbdc", "R6");
    feed_str("abbbc", "R7");
    idle(1, "d");
    feed_str("d", "R8");          check(match_o, 5'b00001, "R8");
    idle(1, "f");
    check(match_o, 5'b00000, "R7");
    clear_flow("R9");
    feed_str("abb", "R8");
    idle(3, "c");
    feed_str("cd", "R8");         check(match_o, 5'b00001, "R8");
    clear_flow("R9");
    feed_str("abbc", "R9");
    clear_flow("R9");
    feed_str("d", "R9");          check(match_o, 5'b00000, "R9");
    feed_str("abc", "R9");
    clear_flow("R9");
    feed_str("f", "R9");          check(match_o, 5'b00000, "R9");
    feed_str("abc", "R10");
    feed("d", "f", 1'b1, "R10");  check(match_o, 5'b00101, "R10");
    clear_flow("R9");
    feed_pairs("abbcexbdcA", "R10");
    feed_pairs("bE", "R10");
    feed("a", "b", 1'b1, "R10");  check(match_o, 5'b01000, "R10");

    for (int i0 = 0; i0 < 8; i0++)
      for (int i1 = 0; i1 < 8; i1++)
        for (int i2 = 0; i2 < 8; i2++)
          for (int i3 = 0; i3 < 8; i3++) begin
            clear_flow("R9");
            feed(alpha[i0], 8'h00, 1'b0, "R6");
            feed(alpha[i1], 8'h00, 1'b0, "R6");
            feed(alpha[i2], 8'h00, 1'b0, "R6");
            feed(alpha[i3], 8'h00, 1'b0, "R6");
            clear_flow("R9");
            feed(alpha[i0], alpha[i1], 1'b1, "R10");
            feed(alpha[i2], alpha[i3], 1'b1, "R10");
          end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule